// File: doc/BRIEF.md
# Condition field mask-mode logic unit

This execution unit handles four predicate operations on a 32-bit condition register. The register is split into eight 4-bit fields. Every operation builds four match terms, one for each bit of a field. A term is set only when its mask bit is set and its mode bit equals the bit under test.

The four operations differ in where the tested bits come from and where the terms go:

- Reduce-to-integer ANDs or ORs the terms into the low bit of a 64-bit result.
- Integer-to-field tests every position against the low bit of an integer operand and writes the terms into a field.
- Field-to-field tests a source field and writes the terms into a destination field.
- Reduce-to-bit ANDs or ORs the terms into one chosen bit of the register.

When the integer register index is zero, the integer operand reads as zero. Mask and mode then act as immediates: a zero mode sets the masked bits, and an all-ones mode clears them.

An operation is presented with `in_valid`. Its results appear registered on the next clock edge, flagged by `out_valid`. Decoding and any looping over vector elements are done outside this block.

Top module: `cfield_mask_unit`

## Requirements
- R1: Field k of the condition register is `cr[31-4k:28-4k]` (field 0 is at the most significant end). Test position i (0..3) of a field is bit `cr[31-4k-i]`. Position i uses mask bit `mask[3-i]` and mode bit `mode[3-i]`. The term for position i is `mask[3-i] AND (mode[3-i] == tested bit i)`.
- R2: Opcode 00 (reduce-to-integer) tests field `src_field`. It drives `int_result[0]` with the OR of the four terms when `m_or`=1, and with their AND when `m_or`=0. `int_result[63:1]` is 0, and `cr_out` equals `cr_in`.
- R3: Opcode 10 (field-to-field) tests field `src_field` and writes the four terms into field `dst_field` of `cr_out`. Term for position i goes to `cr_out[31-4*dst_field-i]`.
- R4: Opcode 01 (integer-to-field) tests every position against `int_src[0]` and writes the terms into field `dst_field`.
- R5: With opcode 01 and `int_src_idx`=0, the tested bit is 0 whatever `int_src` holds, so the written field is `mask & ~mode`.
- R6: Opcode 11 (reduce-to-bit) computes the AND/OR reduction of R2 on `src_field`. It writes the result into field `target[2:0]`, at position `target[4:3]`. No other bit of `cr_out` changes.
- R7: For opcodes 01 and 10, every bit of `cr_out` outside the destination field equals `cr_in`.
- R8: For opcodes 01, 10 and 11, `int_result` is all zeros.
- R9: Results and `out_valid`=1 appear one clock edge after `in_valid`=1. After a cycle with `in_valid`=0, `out_valid` is 0 and the result outputs hold their values. Reset clears `out_valid`, `int_result` and `cr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | 00 reduce-to-integer, 01 integer-to-field, 10 field-to-field, 11 reduce-to-bit |
| mask | input | 4 | Term enable per position |
| mode | input | 4 | Pattern each position is compared with |
| m_or | input | 1 | 1: OR reduction, 0: AND reduction |
| src_field | input | 3 | Field that is tested |
| dst_field | input | 3 | Field written by opcodes 01 and 10 |
| target | input | 5 | Opcode 11 target: [4:3] position, [2:0] field |
| int_src_idx | input | 5 | Integer register index; 0 forces the operand to zero |
| int_src | input | 64 | Integer operand |
| cr_in | input | 32 | Current condition register |
| out_valid | output | 1 | Result outputs are new |
| int_result | output | 64 | Integer result |
| cr_out | output | 32 | Updated condition register |

## Verification
The assertions check the following on every cycle:

- the valid/hold timing;
- that reduce-to-integer leaves the register alone;
- that field writes disturb nothing outside their field;
- that reduce-to-bit changes at most one bit;
- that the integer result is zero except for opcode 00;
- the immediate pattern written with a zero index.

Only the bench scenarios can show that the term values are right. This covers AND versus OR reduction, the ordering of mask and mode bits against field positions, and the placement of a reduced bit at a chosen field and position.

// File: rtl/cfield_mask_unit.sv
module cfield_mask_unit #(
  parameter int XLEN   = 64,
  parameter int NFIELD = 8,
  parameter int FW     = 4,
  parameter int RIDXW  = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [1:0]                        op,
  input  logic [FW-1:0]                     mask,
  input  logic [FW-1:0]                     mode,
  input  logic                              m_or,
  input  logic [$clog2(NFIELD)-1:0]         src_field,
  input  logic [$clog2(NFIELD)-1:0]         dst_field,
  input  logic [$clog2(NFIELD)+$clog2(FW)-1:0] target,
  input  logic [RIDXW-1:0]                  int_src_idx,
  input  logic [XLEN-1:0]                   int_src,
  input  logic [NFIELD*FW-1:0]              cr_in,
  output logic                              out_valid,
  output logic [XLEN-1:0]                   int_result,
  output logic [NFIELD*FW-1:0]              cr_out
);
  localparam int CRW = NFIELD * FW;
  localparam int FIW = $clog2(NFIELD);
  localparam int BIW = $clog2(FW);
  localparam int TW  = FIW + BIW;

  typedef enum logic [1:0] {
    OP_TO_INT = 2'b00, OP_FROM_INT = 2'b01, OP_FIELD = 2'b10, OP_TO_BIT = 2'b11
  } op_e;

  logic [FW-1:0]   src_bits, term_cr, term_int;
  logic            int_lsb, reduced;
  logic [FIW-1:0]  tgt_fld;
  logic [BIW-1:0]  tgt_pos;
  logic [CRW-1:0]  cr_next;
  logic [XLEN-1:0] int_next;
  logic            unused_hi;

  assign unused_hi = ^int_src[XLEN-1:1];
  assign src_bits  = cr_in[CRW-1-FW*int'(src_field) -: FW];
  assign int_lsb   = (int_src_idx != '0) & int_src[0];
  assign term_cr   = mask & ~(mode ^ src_bits);
  assign term_int  = mask & ~(mode ^ {FW{int_lsb}});
  assign reduced   = m_or ? |term_cr : &term_cr;
  assign tgt_pos   = target[TW-1 -: BIW];
  assign tgt_fld   = target[FIW-1:0];

  always_comb begin
    cr_next  = cr_in;
    int_next = '0;
    unique case (op_e'(op))
      OP_TO_INT:   int_next[0] = reduced;
      OP_FROM_INT: cr_next[CRW-1-FW*int'(dst_field) -: FW] = term_int;
      OP_FIELD:    cr_next[CRW-1-FW*int'(dst_field) -: FW] = term_cr;
      OP_TO_BIT:   cr_next[CRW-1-FW*int'(tgt_fld)-int'(tgt_pos)] = reduced;
      default:     ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      int_result <= '0;
      cr_out     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        int_result <= int_next;
        cr_out     <= cr_next;
      end
    end
  end
endmodule

// File: rtl/cfield_mask_unit_chk.sv
module cfield_mask_unit_chk #(
  parameter int XLEN   = 64,
  parameter int NFIELD = 8,
  parameter int FW     = 4,
  parameter int RIDXW  = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic [1:0]                op,
  input logic [FW-1:0]             mask,
  input logic [FW-1:0]             mode,
  input logic [$clog2(NFIELD)-1:0] dst_field,
  input logic [RIDXW-1:0]          int_src_idx,
  input logic [NFIELD*FW-1:0]      cr_in,
  input logic                      out_valid,
  input logic [XLEN-1:0]           int_result,
  input logic [NFIELD*FW-1:0]      cr_out
);
  localparam int CRW = NFIELD * FW;

  function automatic logic [CRW-1:0] fld_window(input logic [$clog2(NFIELD)-1:0] k);
    return {{(CRW-FW){1'b0}}, {FW{1'b1}}} << (FW * (NFIELD - 1 - int'(k)));
  endfunction

  function automatic logic [FW-1:0] fld_get(input logic [CRW-1:0] v,
                                            input logic [$clog2(NFIELD)-1:0] k);
    logic [CRW-1:0] sh;
    sh = v >> (FW * (NFIELD - 1 - int'(k)));
    return sh[FW-1:0];
  endfunction

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(cr_out) && $stable(int_result)));

  assert_int_op_keeps_cr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) == 2'b00) |->
      (cr_out == $past(cr_in) && int_result[XLEN-1:1] == '0));

  assert_outside_field_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(op) == 2'b01 || $past(op) == 2'b10)) |->
      (((cr_out ^ $past(cr_in)) & ~fld_window($past(dst_field))) == '0));

  assert_single_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) == 2'b11) |-> ($countones(cr_out ^ $past(cr_in)) <= 1));

  assert_int_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) != 2'b00) |-> (int_result == '0));

  assert_zero_index_imm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) == 2'b01 && $past(int_src_idx) == '0) |->
      (fld_get(cr_out, $past(dst_field)) == $past(mask & ~mode)));
endmodule

bind cfield_mask_unit cfield_mask_unit_chk #(
  .XLEN(XLEN), .NFIELD(NFIELD), .FW(FW), .RIDXW(RIDXW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .mask(mask),
  .mode(mode), .dst_field(dst_field), .int_src_idx(int_src_idx),
  .cr_in(cr_in), .out_valid(out_valid), .int_result(int_result),
  .cr_out(cr_out)
);

// File: tb/cfield_mask_unit_bench.sv
module cfield_mask_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic [3:0]  mask = '0, mode = '0;
  logic        m_or = 1'b0;
  logic [2:0]  src_field = '0, dst_field = '0;
  logic [4:0]  target = '0, int_src_idx = '0;
  logic [63:0] int_src = '0;
  logic [31:0] cr_in = '0;
  logic        out_valid;
  logic [63:0] int_result;
  logic [31:0] cr_out;

  int tests = 0, fails = 0;

  typedef struct {
    logic [63:0] ei;
    logic [31:0] ec;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  cfield_mask_unit u_cfield_mask_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .mask(mask),
    .mode(mode), .m_or(m_or), .src_field(src_field), .dst_field(dst_field),
    .target(target), .int_src_idx(int_src_idx), .int_src(int_src),
    .cr_in(cr_in), .out_valid(out_valid), .int_result(int_result),
    .cr_out(cr_out)
  );

  function automatic logic term(input logic [3:0] mk, input logic [3:0] md,
                                input int i, input logic b);
    return mk[3-i] && (md[3-i] == b);
  endfunction

  task automatic issue(input logic [1:0] o, input logic [3:0] mk, input logic [3:0] md,
                       input logic mo, input logic [2:0] sf, input logic [2:0] df,
                       input logic [4:0] tg, input logic [4:0] idx,
                       input logic [63:0] isrc, input logic [31:0] cr, input string tag);
    exp_t e;
    logic any, all, t, s;
    any = 1'b0; all = 1'b1;
    e.ei = '0; e.ec = cr; e.tag = tag;
    for (int i = 0; i < 4; i++) begin
      t = term(mk, md, i, cr[31-4*sf-i]);
      any |= t; all &= t;
    end
    s = (idx == 0) ? 1'b0 : isrc[0];
    case (o)
      2'b00: e.ei[0] = mo ? any : all;
      2'b01: for (int i = 0; i < 4; i++) e.ec[31-4*df-i] = term(mk, md, i, s);
      2'b10: for (int i = 0; i < 4; i++) e.ec[31-4*df-i] = term(mk, md, i, cr[31-4*sf-i]);
      default: e.ec[31-4*tg[2:0]-tg[4:3]] = mo ? any : all;
    endcase
    @(negedge clk);
    in_valid = 1'b1; op = o; mask = mk; mode = md; m_or = mo; src_field = sf;
    dst_field = df; target = tg; int_src_idx = idx; int_src = isrc; cr_in = cr;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      cr_in = ~cr_in;
      op = ~op;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      tests++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R9 out_valid=1 with no pending operation, expected 0");
      end else begin
        e = sb.pop_front();
        if (int_result !== e.ei || cr_out !== e.ec) begin
          fails++;
          $display("FAIL %s int=%h cr=%h expected int=%h cr=%h",
                   e.tag, int_result, cr_out, e.ei, e.ec);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog expired, pending=%0d expected 0", sb.size());
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tests++;
    if (out_valid !== 1'b0 || int_result !== '0 || cr_out !== '0) begin
      fails++;
      $display("FAIL R9 reset v=%b int=%h cr=%h expected 0/0/0", out_valid, int_result, cr_out);
    end
    // R2 reduce-to-integer, R8 ops codes
    issue(2'b00, 4'b1111, 4'b1010, 1'b0, 3'd0, 3'd0, 5'd0, 5'd3, 64'd0, 32'hA000_0000, "R2 AND all match");
    issue(2'b00, 4'b1111, 4'b1011, 1'b0, 3'd0, 3'd0, 5'd0, 5'd3, 64'd0, 32'hA000_0000, "R2 AND one miss");
    issue(2'b00, 4'b0001, 4'b0001, 1'b1, 3'd7, 3'd0, 5'd0, 5'd3, 64'd0, 32'h0000_0001, "R2 OR last position");
    issue(2'b00, 4'b0000, 4'b0000, 1'b1, 3'd2, 3'd0, 5'd0, 5'd3, 64'd0, 32'h1234_5678, "R2 OR empty mask");
    issue(2'b00, 4'b0000, 4'b0000, 1'b0, 3'd2, 3'd0, 5'd0, 5'd3, 64'd0, 32'h1234_5678, "R1 AND empty mask");
    // R1 / R3 field-to-field with asymmetric mask
    issue(2'b10, 4'b1100, 4'b1000, 1'b0, 3'd1, 3'd6, 5'd0, 5'd3, 64'd0, 32'h0C00_00F0, "R3 field copy");
    issue(2'b10, 4'b1111, 4'b0000, 1'b0, 3'd3, 3'd3, 5'd0, 5'd3, 64'd0, 32'hFFF5_FFFF, "R3 R7 in-place invert");
    issue(2'b10, 4'b0110, 4'b0110, 1'b0, 3'd4, 3'd0, 5'd0, 5'd3, 64'd0, 32'h5555_AAAA, "R1 mid bits");
    // R4 integer-to-field
    issue(2'b01, 4'b1111, 4'b1100, 1'b0, 3'd0, 3'd2, 5'd0, 5'd9, 64'hFFFF_0000_0000_0001, 32'h8765_4321, "R4 lsb one");
    issue(2'b01, 4'b1111, 4'b1100, 1'b0, 3'd0, 3'd5, 5'd0, 5'd9, 64'h0000_0000_0000_FFFE, 32'h8765_4321, "R4 lsb zero");
    // R5 zero index immediates
    issue(2'b01, 4'b0011, 4'b0000, 1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, "R5 set masked");
    issue(2'b01, 4'b1010, 4'b1111, 1'b0, 3'd0, 3'd7, 5'd0, 5'd0, 64'h1, 32'hFFFF_FFFF, "R5 clear masked");
    // R6 reduce-to-bit placement
    issue(2'b11, 4'b1000, 4'b1000, 1'b1, 3'd0, 3'd0, {2'd2, 3'd5}, 5'd3, 64'd0, 32'h8000_0000, "R6 set pos2 field5");
    issue(2'b11, 4'b1111, 4'b0000, 1'b0, 3'd7, 3'd0, {2'd0, 3'd0}, 5'd3, 64'd0, 32'hFFFF_FFF1, "R6 clear pos0 field0");
    issue(2'b11, 4'b0001, 4'b0000, 1'b1, 3'd7, 3'd0, {2'd3, 3'd7}, 5'd3, 64'd0, 32'h0000_0000, "R6 set last bit");
    issue(2'b00, 4'b0100, 4'b0100, 1'b1, 3'd5, 3'd0, 5'd0, 5'd1, 64'd0, 32'h0000_0400, "R2 back-to-back");
    idle(1);
    held = cr_out;
    idle(3);
    tests++;
    if (out_valid !== 1'b0 || cr_out !== held) begin
      fails++;
      $display("FAIL R9 idle hold v=%b cr=%h expected 0 %h", out_valid, cr_out, held);
    end
    tests++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R9 pending=%0d expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule